// File: doc/BRIEF.md
# Microsecond Compare Timer

This block keeps a free-running 64-bit timestamp and raises a level interrupt when that timestamp reaches a programmed target. The counter advances by one on each cycle in which the tick strobe input is high. A prescaler outside the block drives that strobe once per microsecond from a faster clock. A 64-bit compare register, an enable bit and a sticky match flag provide one-shot event generation.

Software reaches the block through a single-cycle port with valid, write, address and data signals, and reads the 32-bit registers one word at a time. Three measures keep the 32-bit accesses safe:
- Reading the low timestamp word captures the high word in the same cycle, so a following read of the high word belongs to the same sample.
- The target is written high word first. It takes effect only when the low word lands.
- A control write changes the enable bit only when a qualifier bit is set in the same word.

To arm an event, software disables compare, reads the timestamp, writes the target as that timestamp plus a delta, and enables compare again. The smallest delta software uses is 100 ticks. To shut the timer down, software disables compare, writes a target of zero and clears the flag.

Top module: `cmpTimer`

## Requirements
- R1: After reset, the enable bit, the match flag, the compare value and the captured high word read as zero and `irq` is low. The timestamp holds the reset-value parameter, which defaults to zero.
- R2: The timestamp increases by exactly one at each clock edge where `tickIn` is high. It holds its value at edges where `tickIn` is low.
- R3: A read of offset 0x00 returns timestamp bits 31:0 and captures bits 63:32 in the same cycle. A read of offset 0x04 returns the captured word, not the live high word. Read data appears on `regRdata` in the cycle after the request.
- R4: A write to offset 0x0C goes to a staging register only. A write to offset 0x08 loads the full compare value as {staging, written data}. Reads of 0x08 and 0x0C return the active compare value.
- R5: At control offset 0x10, bit 0 is the enable bit and bit 1 is the write qualifier. A write with bit 1 set loads bit 0 into the enable bit. A write with bit 1 clear leaves the enable bit unchanged. A read returns the enable bit in bit 0.
- R6: While compare is enabled, the match flag sets at the first edge where the timestamp is greater than or equal to the compare value. `irq` equals the match flag. After an event is armed with delta d from a timestamp below the target, `irq` first reads high when the timestamp is target+1.
- R7: Writing a word with bit 0 set to status offset 0x14 clears the match flag. Writing bit 0 as zero has no effect. A read returns the flag in bit 0.
- R8: While compare is disabled, the match flag never sets. A flag that is already set stays set until it is cleared.
- R9: When a clear and a match fall in the same cycle while compare is enabled, the flag stays set.
- R10: Reads of any other offset, unaligned ones included, return zero. Writes to those offsets change no register.
- R11: A compare value the timestamp has already passed raises the flag at the first edge after the enable bit is set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| tickIn | input | 1 | Counting strobe, one cycle per microsecond |
| regValid | input | 1 | Register access request |
| regWrite | input | 1 | 1 = write, 0 = read |
| regAddr | input | ADDR_W (5) | Byte offset |
| regWdata | input | 32 | Write data |
| regRdata | output | 32 | Read data, valid the cycle after a read |
| irq | output | 1 | Level-high compare interrupt |

## Verification
Two events can fall in the same cycle: the flag can be cleared while the compare condition still holds. The bench provokes this by enabling compare with a target the timestamp has already passed and then clearing the flag. The flag must read back as set, and it must fall only once compare is disabled. The other collision is a low-word capture at the moment the low word wraps into the high word. Back-to-back read sweeps across that wrap check that each {high, low} pair equals the bench's own tick count for the cycle of the low read.

// File: rtl/cmpTimerPkg.sv
package cmpTimerPkg;
  localparam int WORD_W = 32;

  // register offsets; only word-aligned offsets are decoded
  localparam int OFS_TS_LO  = 'h00;
  localparam int OFS_TS_HI  = 'h04;
  localparam int OFS_CMP_LO = 'h08;
  localparam int OFS_CMP_HI = 'h0C;
  localparam int OFS_CTL    = 'h10;
  localparam int OFS_STAT   = 'h14;

  // control word bit positions
  localparam int CTL_EN_BIT = 0;
  localparam int CTL_WE_BIT = 1;

  // strobes from the register control into the datapath
  typedef struct packed {
    logic              snapTs;
    logic              cmpHiWr;
    logic              cmpLoWr;
    logic [WORD_W-1:0] wdata;
  } dpStrobe_t;
endpackage

// File: rtl/cmpTimerDp.sv
module cmpTimerDp
  import cmpTimerPkg::*;
#(
  parameter logic [2*WORD_W-1:0] CNT_RESET = '0
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tickIn,
  input  dpStrobe_t         strb,
  output logic [WORD_W-1:0] tsLo,
  output logic [WORD_W-1:0] tsHiSnap,
  output logic [WORD_W-1:0] cmpLo,
  output logic [WORD_W-1:0] cmpHi,
  output logic              atOrPast
);
  localparam int CNT_W = 2 * WORD_W;

  logic [CNT_W-1:0]  cnt;
  logic [CNT_W-1:0]  cmpVal;
  logic [WORD_W-1:0] cmpStage;
  logic [WORD_W-1:0] snapHi;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cnt <= CNT_RESET;
    end else if (tickIn) begin
      cnt <= cnt + 1'b1;
    end
  end

  // high word captured in the same cycle as the low word is returned
  always_ff @(posedge clk) begin
    if (!rstN) begin
      snapHi <= '0;
    end else if (strb.snapTs) begin
      snapHi <= cnt[CNT_W-1:WORD_W];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cmpStage <= '0;
      cmpVal   <= '0;
    end else begin
      if (strb.cmpHiWr) cmpStage <= strb.wdata;
      if (strb.cmpLoWr) cmpVal   <= {cmpStage, strb.wdata};
    end
  end

  assign tsLo     = cnt[WORD_W-1:0];
  assign tsHiSnap = snapHi;
  assign cmpLo    = cmpVal[WORD_W-1:0];
  assign cmpHi    = cmpVal[CNT_W-1:WORD_W];
  assign atOrPast = (cnt >= cmpVal);

  // R2
  cnt_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    tickIn |=> cnt == $past(cnt) + 1'b1);
  // R2
  cnt_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !tickIn |=> $stable(cnt));
  // R4
  cmp_stage_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strb.cmpLoWr |=> $stable(cmpVal));
endmodule

// File: rtl/cmpTimerCtrl.sv
module cmpTimerCtrl
  import cmpTimerPkg::*;
#(
  parameter int ADDR_W = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regValid,
  input  logic              regWrite,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [WORD_W-1:0] regWdata,
  input  logic [WORD_W-1:0] tsLo,
  input  logic [WORD_W-1:0] tsHiSnap,
  input  logic [WORD_W-1:0] cmpLo,
  input  logic [WORD_W-1:0] cmpHi,
  input  logic              atOrPast,
  output dpStrobe_t         strb,
  output logic [WORD_W-1:0] regRdata,
  output logic              irq
);
  logic wrReq, rdReq;
  logic selTsLo, selTsHi, selCmpLo, selCmpHi, selCtl, selStat, unmapped;
  logic ctlWr, stClr, stSet;
  logic cmpEn, statusFlag;
  logic [WORD_W-1:0] rdMux;

  assign wrReq = regValid & regWrite;
  assign rdReq = regValid & ~regWrite;

  assign selTsLo  = (regAddr == ADDR_W'(OFS_TS_LO));
  assign selTsHi  = (regAddr == ADDR_W'(OFS_TS_HI));
  assign selCmpLo = (regAddr == ADDR_W'(OFS_CMP_LO));
  assign selCmpHi = (regAddr == ADDR_W'(OFS_CMP_HI));
  assign selCtl   = (regAddr == ADDR_W'(OFS_CTL));
  assign selStat  = (regAddr == ADDR_W'(OFS_STAT));
  assign unmapped = ~(selTsLo | selTsHi | selCmpLo | selCmpHi | selCtl | selStat);

  assign ctlWr = wrReq & selCtl;
  assign stClr = wrReq & selStat & regWdata[0];
  assign stSet = cmpEn & atOrPast;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cmpEn <= 1'b0;
    end else if (ctlWr && regWdata[CTL_WE_BIT]) begin
      cmpEn <= regWdata[CTL_EN_BIT];
    end
  end

  // a standing match outranks a clear in the same cycle
  always_ff @(posedge clk) begin
    if (!rstN) begin
      statusFlag <= 1'b0;
    end else if (stSet) begin
      statusFlag <= 1'b1;
    end else if (stClr) begin
      statusFlag <= 1'b0;
    end
  end

  always_comb begin
    rdMux = '0;
    if (selTsLo)  rdMux = tsLo;
    if (selTsHi)  rdMux = tsHiSnap;
    if (selCmpLo) rdMux = cmpLo;
    if (selCmpHi) rdMux = cmpHi;
    if (selCtl)   rdMux[CTL_EN_BIT] = cmpEn;
    if (selStat)  rdMux[0] = statusFlag;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      regRdata <= '0;
    end else if (rdReq) begin
      regRdata <= rdMux;
    end
  end

  always_comb begin
    strb.snapTs  = rdReq & selTsLo;
    strb.cmpHiWr = wrReq & selCmpHi;
    strb.cmpLoWr = wrReq & selCmpLo;
    strb.wdata   = regWdata;
  end

  assign irq = statusFlag;

  // R5
  ctl_we_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ctlWr && !regWdata[CTL_WE_BIT]) |=> $stable(cmpEn));
  // R9
  set_wins_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cmpEn && atOrPast) |=> statusFlag);
  // R8
  no_new_match_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!cmpEn && !statusFlag) |=> !statusFlag);
  // R7
  w1c_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stClr && !(cmpEn && atOrPast)) |=> !statusFlag);
  // R10
  unmapped_rd_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rdReq && unmapped) |=> regRdata == '0);
endmodule

// File: rtl/cmpTimer.sv
module cmpTimer
  import cmpTimerPkg::*;
#(
  parameter int                  ADDR_W    = 5,
  parameter logic [2*WORD_W-1:0] CNT_RESET = '0
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tickIn,
  input  logic              regValid,
  input  logic              regWrite,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [WORD_W-1:0] regWdata,
  output logic [WORD_W-1:0] regRdata,
  output logic              irq
);
  dpStrobe_t         strb;
  logic [WORD_W-1:0] tsLo, tsHiSnap, cmpLo, cmpHi;
  logic              atOrPast;

  cmpTimerCtrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk(clk), .rstN(rstN),
    .regValid(regValid), .regWrite(regWrite), .regAddr(regAddr), .regWdata(regWdata),
    .tsLo(tsLo), .tsHiSnap(tsHiSnap), .cmpLo(cmpLo), .cmpHi(cmpHi),
    .atOrPast(atOrPast), .strb(strb), .regRdata(regRdata), .irq(irq)
  );

  cmpTimerDp #(.CNT_RESET(CNT_RESET)) u_dp (
    .clk(clk), .rstN(rstN), .tickIn(tickIn), .strb(strb),
    .tsLo(tsLo), .tsHiSnap(tsHiSnap), .cmpLo(cmpLo), .cmpHi(cmpHi),
    .atOrPast(atOrPast)
  );
endmodule

// File: tb/cmpTimer_bench.sv
module cmpTimer_bench;
  localparam logic [63:0] RST_VAL = 64'h0000_0000_FFFF_FF80;
  localparam logic [4:0] A_TSLO = 5'h00, A_TSHI = 5'h04, A_CMPLO = 5'h08,
                         A_CMPHI = 5'h0C, A_CTL = 5'h10, A_STAT = 5'h14;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        tickIn = 1'b0;
  logic        regValid = 1'b0;
  logic        regWrite = 1'b0;
  logic [4:0]  regAddr = '0;
  logic [31:0] regWdata = '0;
  logic [31:0] regRdata;
  logic        irq;

  int total = 0;
  int bad = 0;
  int cycles = 0;
  logic [63:0] mdl;

  always #10 clk = ~clk;

  cmpTimer #(.ADDR_W(5), .CNT_RESET(RST_VAL)) u_cmpTimer (
    .clk(clk), .rstN(rstN), .tickIn(tickIn), .regValid(regValid), .regWrite(regWrite),
    .regAddr(regAddr), .regWdata(regWdata), .regRdata(regRdata), .irq(irq)
  );

  // bench tick count, from the requirement only
  always @(posedge clk) begin
    if (!rstN) mdl <= RST_VAL;
    else if (tickIn) mdl <= mdl + 64'd1;
  end

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 150000) begin
      bad = bad + 1;
      total = total + 1;
      $display("FAIL watchdog: actual=%0d expected<150000", cycles);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    total = total + 1;
    if (!ok) begin
      bad = bad + 1;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic regWr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    regValid = 1'b1; regWrite = 1'b1; regAddr = a; regWdata = d;
    @(negedge clk);
    regValid = 1'b0; regWrite = 1'b0;
  endtask

  task automatic regRd(input logic [4:0] a, output logic [31:0] d, output logic [63:0] cntAt);
    @(negedge clk);
    regValid = 1'b1; regWrite = 1'b0; regAddr = a;
    cntAt = mdl;
    @(negedge clk);
    d = regRdata;
    regValid = 1'b0;
  endtask

  task automatic readTs(output logic [63:0] ts, output logic [63:0] cntAt);
    logic [31:0] lo, hi;
    logic [63:0] dummy;
    regRd(A_TSLO, lo, cntAt);
    regRd(A_TSHI, hi, dummy);
    ts = {hi, lo};
  endtask

  task automatic shutdown();
    regWr(A_CTL, 32'h2);
    regWr(A_CMPHI, 32'h0);
    regWr(A_CMPLO, 32'h0);
    regWr(A_STAT, 32'h1);
  endtask

  initial begin
    logic [31:0] d;
    logic [63:0] c, ts, tgt;
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1 reset state
    check(irq == 1'b0, "R1 irq", {63'd0, irq}, 64'd0);
    regRd(A_TSHI, d, c);  check(d == 32'h0, "R1 snapshot", {32'd0, d}, 64'd0);
    regRd(A_CMPLO, d, c); check(d == 32'h0, "R1 cmp lo", {32'd0, d}, 64'd0);
    regRd(A_CMPHI, d, c); check(d == 32'h0, "R1 cmp hi", {32'd0, d}, 64'd0);
    regRd(A_CTL, d, c);   check(d == 32'h0, "R1 ctl", {32'd0, d}, 64'd0);
    regRd(A_STAT, d, c);  check(d == 32'h0, "R1 stat", {32'd0, d}, 64'd0);
    regRd(A_TSLO, d, c);  check(d == RST_VAL[31:0], "R1 ts reset", {32'd0, d}, {32'd0, RST_VAL[31:0]});

    // R3 coherent pairs swept across the low-word wrap, with gaps of 0..3 cycles
    tickIn = 1'b1;
    for (int k = 0; k < 60; k++) begin
      logic [31:0] lo, hi;
      logic [63:0] dummy;
      regRd(A_TSLO, lo, c);
      repeat (k % 4) @(negedge clk);
      regRd(A_TSHI, hi, dummy);
      check({hi, lo} == c, "R3 coherent read", {hi, lo}, c);
    end

    // R2 gated and sparse ticks
    tickIn = 1'b0;
    regRd(A_TSLO, d, c);
    repeat (5) @(negedge clk);
    begin
      logic [31:0] d2;
      logic [63:0] c2;
      regRd(A_TSLO, d2, c2);
      check(d2 == d, "R2 hold without tick", {32'd0, d2}, {32'd0, d});
    end
    for (int k = 0; k < 24; k++) begin
      @(negedge clk);
      tickIn = (k % 3 == 0);
    end
    regRd(A_TSLO, d, c);
    check(d == c[31:0], "R2 sparse ticks", {32'd0, d}, c);
    tickIn = 1'b0;

    // R10 unmapped offsets
    regWr(5'h18, 32'hFFFF_FFFF);
    regWr(5'h11, 32'h3);
    regRd(5'h18, d, c); check(d == 0, "R10 read 0x18", {32'd0, d}, 0);
    regRd(5'h1C, d, c); check(d == 0, "R10 read 0x1C", {32'd0, d}, 0);
    regRd(5'h02, d, c); check(d == 0, "R10 read 0x02", {32'd0, d}, 0);
    regRd(A_CTL, d, c); check(d == 0, "R10 ctl untouched", {32'd0, d}, 0);
    check(irq == 1'b0, "R10 irq untouched", {63'd0, irq}, 0);

    // R5 write qualifier; compare 0 is already passed
    regWr(A_CTL, 32'h1);
    regRd(A_CTL, d, c); check(d == 0, "R5 no qualifier", {32'd0, d}, 0);
    check(irq == 1'b0, "R8 disabled no match", {63'd0, irq}, 0);
    regWr(A_CTL, 32'h3);
    @(negedge clk);
    check(irq == 1'b1, "R11 passed target fires", {63'd0, irq}, 1);
    regWr(A_CTL, 32'h0);
    regRd(A_CTL, d, c); check(d == 1, "R5 enable kept", {32'd0, d}, 1);
    regWr(A_STAT, 32'h0);
    regRd(A_STAT, d, c); check(d == 1, "R7 zero write no effect", {32'd0, d}, 1);
    regWr(A_STAT, 32'h1);
    regRd(A_STAT, d, c); check(d == 1, "R9 set wins over clear", {32'd0, d}, 1);
    check(irq == 1'b1, "R9 irq held", {63'd0, irq}, 1);
    regWr(A_CTL, 32'h2);
    regRd(A_CTL, d, c); check(d == 0, "R5 disable", {32'd0, d}, 0);
    check(irq == 1'b1, "R8 flag persists disabled", {63'd0, irq}, 1);
    regWr(A_STAT, 32'h1);
    check(irq == 1'b0, "R7 clear", {63'd0, irq}, 0);
    repeat (4) @(negedge clk);
    check(irq == 1'b0, "R8 stays clear", {63'd0, irq}, 0);

    // R4 staging
    regWr(A_CMPHI, 32'h5);
    regRd(A_CMPHI, d, c); check(d == 0, "R4 hi staged only", {32'd0, d}, 0);
    regWr(A_CMPLO, 32'h1234);
    regRd(A_CMPHI, d, c); check(d == 5, "R4 hi active", {32'd0, d}, 5);
    regRd(A_CMPLO, d, c); check(d == 32'h1234, "R4 lo active", {32'd0, d}, 32'h1234);

    // R6 delta sweep with ticks every cycle
    tickIn = 1'b1;
    for (int k = 0; k < 36; k++) begin
      logic [63:0] dlt;
      int w;
      dlt = (k < 34) ? 64'(100 + k) : (k == 34 ? 64'd1000 : 64'd4096);
      regWr(A_CTL, 32'h2);
      readTs(ts, c);
      check(ts == c, "R3 arm read", ts, c);
      tgt = ts + dlt;
      regWr(A_CMPHI, tgt[63:32]);
      regWr(A_CMPLO, tgt[31:0]);
      regWr(A_CTL, 32'h3);
      w = 0;
      while (!irq && w < 10000) begin
        @(negedge clk);
        w++;
      end
      check(irq && mdl == tgt + 1, "R6 fire time", mdl, tgt + 1);
      shutdown();
      @(negedge clk);
      check(irq == 1'b0, "R7 shutdown clears", {63'd0, irq}, 0);
    end

    // R11 target behind the timestamp
    readTs(ts, c);
    tgt = ts - 64'd5;
    regWr(A_CMPHI, tgt[63:32]);
    regWr(A_CMPLO, tgt[31:0]);
    check(irq == 1'b0, "R8 no fire while disabled", {63'd0, irq}, 0);
    regWr(A_CTL, 32'h3);
    @(negedge clk);
    check(irq == 1'b1, "R11 late target", {63'd0, irq}, 1);
    shutdown();

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule